// File: doc/BRIEF.md
# ECC Memory Write Path with Scrubbing

This block sits between a host request port and a memory port whose words are 72 bits wide: 64 data bits and 8 check bits. On every write it computes single-error-correct, double-error-detect (SECDED) check bits for the 64-bit word. A write whose byte enables do not cover all eight bytes is turned into a read-modify-write. The block reads the stored word, merges the enabled bytes into it, encodes the result again and writes it back.

On a read the stored codeword is checked. What happens next depends on a 2-bit integrity mode that is sampled when each request is accepted:

| Mode | Behaviour |
|------|-----------|
| 00 | Nothing is checked. |
| 01 | Errors are reported but not corrected. |
| 10 | Single-bit errors are corrected. |
| 11 | Single-bit errors are corrected, and the corrected word is also written back to the same address. |

Single-bit and multi-bit events each raise a one-cycle pulse that carries the request address. The host side accepts one request at a time and holds ready low while memory work is in progress.

Top module: `ecc_scrub_path`

## Requirements
- R1: In the cycle after synchronous reset, the block is in this state: `req_ready` is 1, and `mem_valid`, `rsp_valid`, `sbe_pulse` and `mbe_pulse` are 0.
- R2: Codeword layout and full writes:
  - Codeword bit 0 is the overall parity of all 72 bits, which is even.
  - Bits 1, 2, 4, 8, 16, 32 and 64 are Hamming check bits, so the XOR of the indices of all set bits in 1..71 is zero.
  - Data bit j is stored at the j-th bit index in 3..71 that is not a power of two, in ascending order.
  - A write with `req_be` = 8'hFF issues exactly one memory write of the encoded word and no memory read.
  - A memory command holds its address, direction and data until `mem_ready` is high.
- R3: A write with `req_be` other than 8'hFF reads the addressed word once. It then writes back the stored data with byte i (bits 8i+7..8i) replaced by the new byte wherever `req_be[i]` is 1.
- R4: In modes 10 and 11, a single-bit error is handled as follows:
  - The error may be in a data bit, a check bit or the parity bit.
  - The corrected data is returned with `rsp_mbe` = 0.
  - `sbe_pulse` is raised in the cycle of `rsp_valid`, with `err_addr` equal to the request address.
  - `sbe_pulse` and `mbe_pulse` are never high together, and `rsp_valid` lasts one cycle.
- R5: In mode 01, a word with a single-bit error is returned exactly as stored, without correction, and `sbe_pulse` is raised.
- R6: In mode 00, the read data is the stored data bits without any change, `rsp_mbe` is 0, and neither pulse is raised, whatever the stored check bits are.
- R7: In modes 01, 10 and 11, a word with two flipped bits is reported as follows:
  - The stored data bits are returned unmodified.
  - `rsp_mbe` is 1.
  - `mbe_pulse` is raised.
- R8: Scrub behaviour depends on the mode:
  - In mode 11, a corrected single-bit error is followed by a memory write of the fully corrected codeword to the same address, so a second read finds no error.
  - In mode 10, no write is made and the error remains in memory.
- R9: A multi-bit error never causes a memory write. A partial write that finds a multi-bit error is dropped and leaves the memory word unchanged, while `mbe_pulse` is still raised.
- R10: `req_ready` is 0 whenever a memory command is pending. Through a read-modify-write or a scrub writeback, it stays 0 until the final memory write is accepted, so a request that follows is held until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| integ_mode | input | 2 | Integrity mode, sampled when a request is accepted |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for a write |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 64 | Read data |
| rsp_mbe | output | 1 | Read data carries an uncorrectable error |
| mem_valid | output | 1 | Memory command pending |
| mem_ready | input | 1 | Memory accepts the command |
| mem_write | output | 1 | Memory command is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 72 | Encoded codeword to write |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 72 | Codeword read from memory |
| sbe_pulse | output | 1 | Single-bit error seen (one cycle) |
| mbe_pulse | output | 1 | Multi-bit error seen (one cycle) |
| err_addr | output | AW | Address of the error reported by the pulse |

## Verification
The two functions that meet in one window are the read response with scrub writeback and the host's next request. In mode 11 a corrected read returns its data while the scrub write of the same word is still queued toward memory. The bench provokes this by injecting a single-bit flip and stalling `mem_ready` on alternate cycles. It then issues a second read of the same address immediately after the first response, which must wait behind the scrub. The bench judges the result in three ways: the second read must come back clean with no pulse, the memory model must hold the original clean codeword, and `req_ready` must never be high while a memory command is pending.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RWAIT,
    ST_EVAL,
    ST_WR
  } ecc_st_t;

  // number of Hamming check bits needed for dw data bits
  function automatic int unsigned chk_bits(input int unsigned dw);
    int unsigned p;
    p = 0;
    while ((1 << p) < (dw + p + 1)) p++;
    return p;
  endfunction

  // codeword index of data bit j: j-th non power-of-two index from 3 upward
  function automatic int unsigned data_pos(input int unsigned j);
    int unsigned n;
    int unsigned pos;
    n = 0;
    pos = 0;
    for (int unsigned i = 3; i < 1024; i++) begin
      if (((i & (i - 1)) != 0) && (pos == 0)) begin
        if (n == j) pos = i;
        n++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
  parameter int unsigned DW = 64,
  localparam int unsigned PW = ecc_pkg::chk_bits(DW),
  localparam int unsigned CW = DW + PW + 1
) (
  input  logic [DW-1:0] din,
  output logic [CW-1:0] cw
);

  logic [CW-1:0] base;
  logic [PW-1:0] pb;

  // scatter data bits; check and parity positions start at zero
  for (genvar g = 0; g < CW; g++) begin : g_zero
    if (g == 0 || ((g & (g - 1)) == 0)) begin : g_p
      assign base[g] = 1'b0;
    end
  end
  for (genvar j = 0; j < DW; j++) begin : g_place
    assign base[ecc_pkg::data_pos(j)] = din[j];
  end

  always_comb begin
    for (int k = 0; k < PW; k++) begin
      pb[k] = 1'b0;
      for (int i = 1; i < CW; i++) begin
        if (((i >> k) & 1) == 1) pb[k] = pb[k] ^ base[i];
      end
    end
    cw = base;
    for (int k = 0; k < PW; k++) cw[1 << k] = pb[k];
    cw[0] = ^cw[CW-1:1];
  end

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
  parameter int unsigned DW = 64,
  localparam int unsigned PW = ecc_pkg::chk_bits(DW),
  localparam int unsigned CW = DW + PW + 1
) (
  input  logic [CW-1:0] cw,
  output logic [DW-1:0] raw,
  output logic [DW-1:0] fix,
  output logic          single,
  output logic          multi
);

  logic [PW-1:0] syn;
  logic          par;
  logic [CW-1:0] fixcw;

  always_comb begin
    syn = '0;
    for (int i = 1; i < CW; i++) begin
      if (cw[i]) syn = syn ^ PW'(i);
    end
    par    = ^cw;
    single = par && (int'(syn) < CW);
    multi  = (!par && (syn != '0)) || (par && (int'(syn) >= CW));
    for (int i = 0; i < CW; i++) begin
      fixcw[i] = cw[i] ^ (single && (syn == PW'(i)));
    end
  end

  for (genvar j = 0; j < DW; j++) begin : g_pick
    assign raw[j] = cw[ecc_pkg::data_pos(j)];
    assign fix[j] = fixcw[ecc_pkg::data_pos(j)];
  end

endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 64,
  localparam int unsigned BW = DW / 8,
  localparam int unsigned PW = ecc_pkg::chk_bits(DW),
  localparam int unsigned CW = DW + PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    integ_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [BW-1:0] req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_mbe,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [CW-1:0] mem_rdata,
  output logic          sbe_pulse,
  output logic          mbe_pulse,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] enc_din,
  output logic [CW-1:0] dec_cw,
  input  logic [DW-1:0] dec_raw,
  input  logic [DW-1:0] dec_fix,
  input  logic          dec_single,
  input  logic          dec_multi
);
  import ecc_pkg::*;

  ecc_st_t       st;
  logic [AW-1:0] a_q;
  logic [1:0]    mode_q;
  logic          wr_q;
  logic [DW-1:0] wd_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] wb_q;
  logic [CW-1:0] raw_q;

  logic          chk_on;
  logic          sbe_ev;
  logic          mbe_ev;
  logic [DW-1:0] sel;
  logic [DW-1:0] merged;

  assign chk_on = (mode_q != 2'b00);
  assign sbe_ev = chk_on && dec_single;
  assign mbe_ev = chk_on && dec_multi;
  assign sel    = (mode_q[1] && !dec_multi) ? dec_fix : dec_raw;

  for (genvar b = 0; b < BW; b++) begin : g_merge
    assign merged[b*8 +: 8] = be_q[b] ? wd_q[b*8 +: 8] : sel[b*8 +: 8];
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_valid = (st == ST_RD) || (st == ST_WR);
  assign mem_write = (st == ST_WR);
  assign mem_addr  = a_q;
  assign enc_din   = wb_q;
  assign dec_cw    = raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      a_q       <= '0;
      mode_q    <= 2'b00;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      be_q      <= '0;
      wb_q      <= '0;
      raw_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_mbe   <= 1'b0;
      sbe_pulse <= 1'b0;
      mbe_pulse <= 1'b0;
      err_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      sbe_pulse <= 1'b0;
      mbe_pulse <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            a_q    <= req_addr;
            mode_q <= integ_mode;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            be_q   <= req_be;
            wb_q   <= req_wdata;
            st     <= (req_write && (&req_be)) ? ST_WR : ST_RD;
          end
        end
        ST_RD: begin
          if (mem_ready) st <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (mem_rvalid) begin
            raw_q <= mem_rdata;
            st    <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          sbe_pulse <= sbe_ev;
          mbe_pulse <= mbe_ev;
          err_addr  <= a_q;
          if (!wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= sel;
            rsp_mbe   <= mbe_ev;
            if ((mode_q == 2'b11) && sbe_ev) begin
              wb_q <= dec_fix;
              st   <= ST_WR;
            end else begin
              st <= ST_IDLE;
            end
          end else if (mbe_ev) begin
            st <= ST_IDLE;
          end else begin
            wb_q <= merged;
            st   <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ecc_scrub_path.sv
module ecc_scrub_path #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 64,
  localparam int unsigned BW = DW / 8,
  localparam int unsigned PW = ecc_pkg::chk_bits(DW),
  localparam int unsigned CW = DW + PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    integ_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [BW-1:0] req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_mbe,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [CW-1:0] mem_rdata,
  output logic          sbe_pulse,
  output logic          mbe_pulse,
  output logic [AW-1:0] err_addr
);

  logic [DW-1:0] enc_din;
  logic [CW-1:0] dec_cw;
  logic [DW-1:0] dec_raw;
  logic [DW-1:0] dec_fix;
  logic          dec_single;
  logic          dec_multi;

  ecc_enc #(.DW(DW)) u_enc (
    .din (enc_din),
    .cw  (mem_wdata)
  );

  ecc_dec #(.DW(DW)) u_dec (
    .cw     (dec_cw),
    .raw    (dec_raw),
    .fix    (dec_fix),
    .single (dec_single),
    .multi  (dec_multi)
  );

  ecc_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .integ_mode (integ_mode),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_mbe    (rsp_mbe),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .sbe_pulse  (sbe_pulse),
    .mbe_pulse  (mbe_pulse),
    .err_addr   (err_addr),
    .enc_din    (enc_din),
    .dec_cw     (dec_cw),
    .dec_raw    (dec_raw),
    .dec_fix    (dec_fix),
    .dec_single (dec_single),
    .dec_multi  (dec_multi)
  );

endmodule

// File: rtl/ecc_scrub_chk.sv
module ecc_scrub_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 72
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_mbe,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] mem_wdata,
  input logic          sbe_pulse,
  input logic          mbe_pulse
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (req_ready && !mem_valid && !rsp_valid && !sbe_pulse && !mbe_pulse));

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  // R4
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sbe_pulse, mbe_pulse}));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7
  mbe_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_mbe) |-> mbe_pulse);

  // R9
  no_mbe_wb_chk: assert property (@(posedge clk) disable iff (rst)
    mbe_pulse |-> !mem_valid);

endmodule

bind ecc_scrub_path ecc_scrub_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_mbe   (rsp_mbe),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .sbe_pulse (sbe_pulse),
  .mbe_pulse (mbe_pulse)
);

// File: tb/tb_ecc_scrub_path.sv
module tb_ecc_scrub_path;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    integ_mode = 2'b10;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic [7:0]    req_be = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_rdata;
  logic          rsp_mbe;
  logic          mem_valid;
  logic          mem_ready = 1'b1;
  logic          mem_write;
  logic [AW-1:0] mem_addr;
  logic [71:0]   mem_wdata;
  logic          mem_rvalid = 1'b0;
  logic [71:0]   mem_rdata = '0;
  logic          sbe_pulse;
  logic          mbe_pulse;
  logic [AW-1:0] err_addr;

  always #2.5 clk = ~clk;

  ecc_scrub_path #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .integ_mode(integ_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_mbe(rsp_mbe),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .sbe_pulse(sbe_pulse), .mbe_pulse(mbe_pulse),
    .err_addr(err_addr)
  );

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int viol = 0;
  int cyc = 0;
  bit stall_en = 0;
  bit seen_sbe = 0;
  bit seen_mbe = 0;
  logic [71:0] mem [0:15];
  bit rd_pend = 0;
  logic [3:0] pend_a = '0;

  // data bit j lives at the j-th non power-of-two index from 3 upward
  function automatic int pos_of(input int j);
    int n = 0;
    for (int i = 3; i < 72; i++) begin
      if ((i & (i - 1)) != 0) begin
        if (n == j) return i;
        n++;
      end
    end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model and bus monitor, driven away from the active edge
  always @(negedge clk) begin
    bit nr;
    bit acc;
    cyc++;
    nr = stall_en ? cyc[0] : 1'b1;
    mem_ready = nr;
    acc = mem_valid && nr;
    mem_rvalid = rd_pend;
    mem_rdata = mem[pend_a];
    rd_pend = acc && !mem_write;
    pend_a = mem_addr[3:0];
    if (acc && mem_write) begin
      mem[mem_addr[3:0]] = mem_wdata;
      wr_cnt++;
    end
    if (acc && !mem_write) rd_cnt++;
    if (mem_valid && req_ready) viol++;
    if (sbe_pulse) seen_sbe = 1;
    if (mbe_pulse) seen_mbe = 1;
  end

  task automatic host_req(input bit w, input int a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input int a, input logic [63:0] d, input logic [7:0] be);
    seen_sbe = 0; seen_mbe = 0;
    host_req(1, a, d, be);
    wait_idle();
    @(negedge clk);
  endtask

  task automatic do_read(input int a, input logic [63:0] ed, input bit emb,
                         input bit esp, input bit emp, input string tag);
    int n = 0;
    seen_sbe = 0; seen_mbe = 0;
    host_req(0, a, '0, '0);
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    chk(rsp_valid && rsp_rdata == ed, {tag, " data"}, {8'h0, rsp_rdata}, {8'h0, ed});
    chk(rsp_mbe == emb && sbe_pulse == esp && mbe_pulse == emp, {tag, " flags"},
        {69'h0, rsp_mbe, sbe_pulse, mbe_pulse}, {69'h0, emb, esp, emp});
    if (esp || emp) chk(err_addr == AW'(a), {tag, " err_addr"}, 72'(err_addr), 72'(a));
    @(negedge clk);
    wait_idle();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [63:0] d0, d2, d3, d4, m;
    logic [71:0] clean, cw;
    int w0, r0, x;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !mem_valid && !rsp_valid && !sbe_pulse && !mbe_pulse, "R1 reset",
        {67'h0, req_ready, mem_valid, rsp_valid, sbe_pulse, mbe_pulse}, 72'h10);

    // R2 full write, layout and readback
    integ_mode = 2'b10;
    d0 = 64'h0123_4567_89AB_CDEF;
    w0 = wr_cnt; r0 = rd_cnt;
    do_write(0, d0, 8'hFF);
    chk(wr_cnt == w0 + 1 && rd_cnt == r0, "R2 one write no read", 72'(wr_cnt - w0), 72'd1);
    cw = mem[0];
    m = '0;
    for (int j = 0; j < 64; j++) m[j] = cw[pos_of(j)];
    chk(m == d0, "R2 data placement", {8'h0, m}, {8'h0, d0});
    x = 0;
    for (int i = 1; i < 72; i++) if (cw[i]) x = x ^ i;
    chk(x == 0 && (^cw) == 1'b0, "R2 check bits", 72'(x), 72'd0);
    do_read(0, d0, 0, 0, 0, "R2 readback");

    // R3 partial write merge
    w0 = wr_cnt; r0 = rd_cnt;
    do_write(0, 64'hFFEE_DDCC_BBAA_9988, 8'h0F);
    chk(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R3 rmw traffic",
        72'((wr_cnt - w0) * 16 + (rd_cnt - r0)), 72'h11);
    do_read(0, 64'h0123_4567_BBAA_9988, 0, 0, 0, "R3 merged");

    // R4 correction in mode 10, R8 no writeback in mode 10
    d2 = 64'hDEAD_BEEF_0BAD_F00D;
    do_write(1, d2, 8'hFF);
    clean = mem[1];
    mem[1][pos_of(13)] = ~mem[1][pos_of(13)];
    w0 = wr_cnt;
    do_read(1, d2, 0, 1, 0, "R4 corrected");
    chk(wr_cnt == w0, "R8 mode10 no writeback", 72'(wr_cnt - w0), 72'd0);
    do_read(1, d2, 0, 1, 0, "R8 error still present");

    // R5 detect only
    integ_mode = 2'b01;
    do_read(1, d2 ^ (64'd1 << 13), 0, 1, 0, "R5 detect only");
    // R6 no checking
    integ_mode = 2'b00;
    do_read(1, d2 ^ (64'd1 << 13), 0, 0, 0, "R6 raw");

    // R8 scrub writeback
    integ_mode = 2'b11;
    w0 = wr_cnt;
    do_read(1, d2, 0, 1, 0, "R8 scrub read");
    chk(wr_cnt == w0 + 1 && mem[1] == clean, "R8 scrubbed word", mem[1], clean);
    do_read(1, d2, 0, 0, 0, "R8 clean after scrub");

    // R7 double error, R9 no writeback
    mem[1][pos_of(5)] = ~mem[1][pos_of(5)];
    mem[1][pos_of(40)] = ~mem[1][pos_of(40)];
    cw = mem[1];
    w0 = wr_cnt;
    do_read(1, d2 ^ (64'd1 << 5) ^ (64'd1 << 40), 1, 0, 1, "R7 double");
    chk(wr_cnt == w0, "R9 no writeback on mbe", 72'(wr_cnt - w0), 72'd0);
    integ_mode = 2'b00;
    do_read(1, d2 ^ (64'd1 << 5) ^ (64'd1 << 40), 0, 0, 0, "R6 double ignored");
    integ_mode = 2'b10;
    do_write(1, 64'h0000_0000_0000_00FF, 8'h01);
    chk(mem[1] == cw && seen_mbe, "R9 rmw dropped", mem[1], cw);

    // R4 parity-bit-only flip, R8 written back
    integ_mode = 2'b11;
    d3 = 64'h5555_AAAA_3C3C_C3C3;
    do_write(2, d3, 8'hFF);
    clean = mem[2];
    mem[2][0] = ~mem[2][0];
    do_read(2, d3, 0, 1, 0, "R4 parity bit");
    chk(mem[2] == clean, "R8 parity bit scrubbed", mem[2], clean);

    // R10 scrub and following request with a stalling memory
    stall_en = 1;
    d4 = 64'h8001_2345_6789_ABCD;
    do_write(3, d4, 8'hFF);
    clean = mem[3];
    mem[3][pos_of(63)] = ~mem[3][pos_of(63)];
    seen_sbe = 0;
    host_req(0, 3, '0, '0);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == d4 && sbe_pulse, "R10 first read", {8'h0, rsp_rdata}, {8'h0, d4});
    do_read(3, d4, 0, 0, 0, "R10 follow-up read clean");
    chk(mem[3] == clean, "R10 scrub landed", mem[3], clean);
    integ_mode = 2'b10;
    do_write(3, 64'h1111_2222_3333_4444, 8'hF0);
    do_read(3, 64'h1111_2222_6789_ABCD, 0, 0, 0, "R3 merge under stall");
    stall_en = 0;
    chk(viol == 0, "R10 ready low while busy", 72'(viol), 72'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule